// File: doc/BRIEF.md
# Cross-Domain Configuration Write Bridge with Batched Release

This block carries configuration writes from a fast bus clock into a slow counter clock. It holds three fast-side shadow registers: a narrow control word and two wide compare values. It also drives the matching slow-side copies that the counter logic uses. Each accepted write is queued for transfer. One toggle request crosses into the slow clock through a two-flop synchronizer. The slow side loads the selected registers and returns a toggle acknowledge through another two-flop synchronizer. The data and the register mask stay frozen in fast-side snapshot flops for the whole flight, so the slow side samples them only after the synchronized request has toggled.

Software polls a status word to see which registers are still crossing. A write to a register that is still crossing is dropped and sets a sticky error bit. A hold mode lets software gather several writes in the shadows without sending them. Leaving hold sends every register written during the hold in one single transfer, so the slow side sees all of them change on the same slow clock edge.

Top module: `lf_regsync_bridge`

## Requirements
- R1: After reset, the shadows read back CTRL_RST (address 0) and CMP_RST (addresses 1 and 2). The hold bit (address 3, bit 0) reads 0, the status word (address 4) reads 0, and the slow-side outputs hold the same reset values.
- R2: Outside hold mode, an accepted write to address 0, 1 or 2 sets busy bit 0, 1 or 2 of the status word. The bit is visible from the next bus cycle on, and the shadow reads back the written value.
- R3: A busy bit clears only after the slow-side output of that register already shows the written value.
- R4: A write to a register whose busy bit is set is dropped: the shadow and the slow-side output keep their values, and status bit 3 (error) becomes 1.
- R5: The error bit stays set until a write to address 4 with data bit 3 equal to 1 clears it.
- R6: While the hold bit is 1, writes to addresses 0 to 2 update the shadows and set dirty bits 4 to 6 of the status word. They do not set busy bits, and a dirty register may be written again without an error.
- R7: While the hold bit is 1, no slow-side output changes because of writes made during the hold.
- R8: Writing 0 to the hold bit while it is 1 clears all dirty bits. From the next bus cycle on, it sets the busy bits of exactly the registers that were dirty.
- R9: All registers released together change on the same slow clock edge.
- R10: The slow-side outputs change only when a transfer completes. Every transfer delivers the shadow values present at launch, in launch order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| lf_clk | input | 1 | Slow counter clock |
| lf_rst_n | input | 1 | Active-low reset, slow domain |
| lf_ctrl | output | CTRL_W | Control word in the slow domain |
| lf_cmpa | output | DATA_W | First compare value in the slow domain |
| lf_cmpb | output | DATA_W | Second compare value in the slow domain |

## Verification
A lost or stuck pending bit shows up on the status word in the cycle after the write. A stale snapshot shows up on the slow-side outputs within about five slow clock cycles, as a value that differs from the one that was written. A split release, where the dirty registers leave in separate transfers, makes the slow outputs change on two separate slow edges. The scoreboard reports that as an extra, unexpected update. A broken drop or error path shows up on the next status read, or as a slow-side value that a dropped write should never have produced.

// File: rtl/rsync_pkg.sv
package rsync_pkg;
  localparam int NREG = 3;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_CMPA = 3'd1,
    A_CMPB = 3'd2,
    A_HOLD = 3'd3,
    A_STAT = 3'd4
  } reg_addr_e;

  localparam int ERR_BIT   = 3;
  localparam int DIRTY_LSB = 4;

  // one-hot register select for the three synchronized registers
  function automatic logic [NREG-1:0] reg_select(input logic [ADDR_W-1:0] a);
    logic [NREG-1:0] s;
    s = '0;
    if (a < ADDR_W'(NREG)) s[a[1:0]] = 1'b1;
    return s;
  endfunction

  // status word layout: busy[2:0], err[3], dirty[6:4]
  function automatic logic [7:0] pack_status(input logic [NREG-1:0] busy,
                                             input logic err,
                                             input logic [NREG-1:0] dirty);
    return {1'b0, dirty, err, busy};
  endfunction
endpackage

// File: rtl/rs_sync2.sv
module rs_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rs_bus_regs.sv
module rs_bus_regs
  import rsync_pkg::*;
#(
  parameter int          DATA_W   = 24,
  parameter int          CTRL_W   = 4,
  parameter logic [CTRL_W-1:0] CTRL_RST = '0,
  parameter logic [DATA_W-1:0] CMP_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ack_s,
  output logic              req_tog,
  output logic [NREG-1:0]   xfer_mask,
  output logic [CTRL_W-1:0] snap_ctrl,
  output logic [DATA_W-1:0] snap_cmpa,
  output logic [DATA_W-1:0] snap_cmpb
);
  localparam int STAT_W = 8;

  logic [CTRL_W-1:0] sh_ctrl;
  logic [DATA_W-1:0] sh_cmpa, sh_cmpb;
  logic [NREG-1:0]   pend, infl, dirty;
  logic              freeze, err, active;

  // named internal events
  logic [NREG-1:0] hit, busy, take_mask;
  logic            wr_reg, wr_drop, wr_take, freeze_clr, err_clr, launch, done;

  assign busy       = pend | infl;
  assign wr_reg     = wr && (addr < ADDR_W'(NREG));
  assign hit        = wr_reg ? reg_select(addr) : '0;
  assign wr_drop    = |(hit & busy);
  assign take_mask  = hit & ~busy;
  assign wr_take    = |take_mask;
  assign freeze_clr = wr && (addr == A_HOLD) && !wdata[0] && freeze;
  assign err_clr    = wr && (addr == A_STAT) && wdata[ERR_BIT];
  assign done       = active && (ack_s == req_tog);
  assign launch     = !freeze && !active && (pend != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ctrl <= CTRL_RST;
      sh_cmpa <= CMP_RST;
      sh_cmpb <= CMP_RST;
    end else if (wr_take) begin
      if (take_mask[0]) sh_ctrl <= wdata[CTRL_W-1:0];
      if (take_mask[1]) sh_cmpa <= wdata;
      if (take_mask[2]) sh_cmpb <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      dirty <= '0;
    end else begin
      pend  <= (launch ? '0 : pend) | (freeze ? '0 : take_mask) | (freeze_clr ? dirty : '0);
      dirty <= freeze_clr ? '0 : (dirty | (freeze ? take_mask : '0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl      <= '0;
      active    <= 1'b0;
      req_tog   <= 1'b0;
      xfer_mask <= '0;
      snap_ctrl <= CTRL_RST;
      snap_cmpa <= CMP_RST;
      snap_cmpb <= CMP_RST;
    end else if (launch) begin
      infl      <= pend;
      active    <= 1'b1;
      req_tog   <= ~req_tog;
      xfer_mask <= pend;
      snap_ctrl <= sh_ctrl;
      snap_cmpa <= sh_cmpa;
      snap_cmpb <= sh_cmpb;
    end else if (done) begin
      infl   <= '0;
      active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (wr && addr == A_HOLD) freeze <= wdata[0];
      if (wr_drop) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CTRL_W-1:0] = sh_ctrl;
      A_CMPA:  rdata = sh_cmpa;
      A_CMPB:  rdata = sh_cmpb;
      A_HOLD:  rdata[0] = freeze;
      A_STAT:  rdata[STAT_W-1:0] = pack_status(busy, err, dirty);
      default: rdata = '0;
    endcase
  end

  // R3: the snapshot seen by the slow side stays put while in flight
  p_snap_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> $stable({snap_ctrl, snap_cmpa, snap_cmpb, xfer_mask}));
  // R4: a dropped write raises the error flag and leaves its shadow alone
  p_drop_sets_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> err);
  p_drop_keeps_shadow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && hit[1]) |=> $stable(sh_cmpa));
  // R5: error is sticky until the clearing write
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
  // R6: a write made during hold never becomes busy on its own
  p_hold_write_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && wr_take) |=> ((pend & $past(take_mask)) == '0));
  // R7: nothing leaves while held
  p_no_launch_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !launch);
  // R8: release turns every dirty register busy and empties the dirty set
  p_release_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_clr |=> (((busy & $past(dirty)) == $past(dirty)) && dirty == '0));
  // R10: the request toggles only on a launch
  p_req_only_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(req_tog));
endmodule

// File: rtl/rs_lf_load.sv
module rs_lf_load
  import rsync_pkg::*;
#(
  parameter int          DATA_W   = 24,
  parameter int          CTRL_W   = 4,
  parameter logic [CTRL_W-1:0] CTRL_RST = '0,
  parameter logic [DATA_W-1:0] CMP_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic [NREG-1:0]   xfer_mask,
  input  logic [CTRL_W-1:0] snap_ctrl,
  input  logic [DATA_W-1:0] snap_cmpa,
  input  logic [DATA_W-1:0] snap_cmpb,
  output logic              ack_tog,
  output logic [CTRL_W-1:0] lf_ctrl,
  output logic [DATA_W-1:0] lf_cmpa,
  output logic [DATA_W-1:0] lf_cmpb
);
  logic req_d;
  logic load_evt;

  assign load_evt = req_s ^ req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d   <= 1'b0;
      ack_tog <= 1'b0;
      lf_ctrl <= CTRL_RST;
      lf_cmpa <= CMP_RST;
      lf_cmpb <= CMP_RST;
    end else begin
      req_d <= req_s;
      if (load_evt) begin
        ack_tog <= req_s;
        if (xfer_mask[0]) lf_ctrl <= snap_ctrl;
        if (xfer_mask[1]) lf_cmpa <= snap_cmpa;
        if (xfer_mask[2]) lf_cmpb <= snap_cmpb;
      end
    end
  end

  // R10: slow outputs move only on a synchronized request edge
  p_quiet_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable({lf_ctrl, lf_cmpa, lf_cmpb}));
  // R3: acknowledge is returned on the same edge that loads the data
  p_ack_with_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (ack_tog == $past(req_s)));
endmodule

// File: rtl/lf_regsync_bridge.sv
module lf_regsync_bridge
  import rsync_pkg::*;
#(
  parameter int          DATA_W   = 24,
  parameter int          CTRL_W   = 4,
  parameter int          SYNC_STG = 2,
  parameter logic [CTRL_W-1:0] CTRL_RST = '0,
  parameter logic [DATA_W-1:0] CMP_RST  = '0
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lf_clk,
  input  logic              lf_rst_n,
  output logic [CTRL_W-1:0] lf_ctrl,
  output logic [DATA_W-1:0] lf_cmpa,
  output logic [DATA_W-1:0] lf_cmpb
);
  logic              req_tog, req_s, ack_tog, ack_s;
  logic [NREG-1:0]   xfer_mask;
  logic [CTRL_W-1:0] snap_ctrl;
  logic [DATA_W-1:0] snap_cmpa, snap_cmpb;

  rs_bus_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .CTRL_RST(CTRL_RST), .CMP_RST(CMP_RST)) u_bus (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .ack_s(ack_s), .req_tog(req_tog), .xfer_mask(xfer_mask),
    .snap_ctrl(snap_ctrl), .snap_cmpa(snap_cmpa), .snap_cmpb(snap_cmpb)
  );

  rs_sync2 #(.STAGES(SYNC_STG)) u_req_sync (
    .clk(lf_clk), .rst_n(lf_rst_n), .d(req_tog), .q(req_s)
  );

  rs_sync2 #(.STAGES(SYNC_STG)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tog), .q(ack_s)
  );

  rs_lf_load #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .CTRL_RST(CTRL_RST), .CMP_RST(CMP_RST)) u_lf (
    .clk(lf_clk), .rst_n(lf_rst_n), .req_s(req_s), .xfer_mask(xfer_mask),
    .snap_ctrl(snap_ctrl), .snap_cmpa(snap_cmpa), .snap_cmpb(snap_cmpb),
    .ack_tog(ack_tog), .lf_ctrl(lf_ctrl), .lf_cmpa(lf_cmpa), .lf_cmpb(lf_cmpb)
  );
endmodule

// File: tb/lf_regsync_bridge_bench.sv
module lf_regsync_bridge_bench;
  localparam int DW = 24;
  localparam int CW = 4;
  localparam int TW = CW + 2*DW;

  logic          bus_clk = 1'b0, lf_clk = 1'b0;
  logic          bus_rst_n = 1'b0, lf_rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [CW-1:0] lf_ctrl;
  logic [DW-1:0] lf_cmpa, lf_cmpb;

  int checks = 0, fails = 0;
  logic [TW-1:0] exp_q[$];
  logic [TW-1:0] prev;
  logic          mon_en = 1'b0;

  always #10 bus_clk = ~bus_clk;
  always #61 lf_clk  = ~lf_clk;

  lf_regsync_bridge u_lf_regsync_bridge (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lf_clk(lf_clk), .lf_rst_n(lf_rst_n),
    .lf_ctrl(lf_ctrl), .lf_cmpa(lf_cmpa), .lf_cmpb(lf_cmpb)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge bus_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_lf(input logic [CW-1:0] c, input logic [DW-1:0] a, input logic [DW-1:0] b);
    exp_q.push_back({c, a, b});
  endtask

  task automatic wait_idle(input string req);
    logic [DW-1:0] s;
    bit ok = 0;
    for (int i = 0; i < 400; i++) begin
      rd_reg(3'd4, s);
      if (s[2:0] == 3'b000) begin ok = 1; break; end
    end
    chk(req, ok, 1);
  endtask

  // monitor: every change of the slow outputs must match the next expected item
  always @(negedge lf_clk) begin
    if (mon_en) begin
      logic [TW-1:0] cur;
      cur = {lf_ctrl, lf_cmpa, lf_cmpb};
      if (cur !== prev) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R9/R10 unexpected update actual=%h expected=none", cur);
        end else begin
          logic [TW-1:0] e;
          e = exp_q.pop_front();
          chk("R9/R10 scoreboard", 64'(cur), 64'(e));
        end
      end
      prev = cur;
    end
  end

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    #250;
    @(negedge bus_clk); bus_rst_n = 1'b1; lf_rst_n = 1'b1;
    prev = '0;
    // R1 reset state
    rd_reg(3'd0, r); chk("R1 ctrl shadow", r, 0);
    rd_reg(3'd1, r); chk("R1 cmpa shadow", r, 0);
    rd_reg(3'd3, r); chk("R1 hold", r, 0);
    rd_reg(3'd4, r); chk("R1 status", r, 0);
    chk("R1 slow outputs", {lf_ctrl, lf_cmpa, lf_cmpb}, 0);
    mon_en = 1'b1;

    // R2/R3 plain write of the control word
    expect_lf(4'h5, 24'h0, 24'h0);
    wr_reg(3'd0, 24'h5);
    rd_reg(3'd4, r); chk("R2 busy ctrl", r[2:0], 3'b001);
    rd_reg(3'd0, r); chk("R2 shadow ctrl", r, 5);
    wait_idle("R3 idle");
    chk("R3 slow ctrl when idle", lf_ctrl, 5);

    // R2/R3 compare writes
    expect_lf(4'h5, 24'h123456, 24'h0);
    wr_reg(3'd1, 24'h123456);
    rd_reg(3'd4, r); chk("R2 busy cmpa", r[2:0], 3'b010);
    wait_idle("R3 idle a");
    chk("R3 slow cmpa", lf_cmpa, 24'h123456);
    expect_lf(4'h5, 24'h123456, 24'h00abcd);
    wr_reg(3'd2, 24'h00abcd);
    rd_reg(3'd4, r); chk("R2 busy cmpb", r[2:0], 3'b100);
    wait_idle("R3 idle b");
    chk("R3 slow cmpb", lf_cmpb, 24'h00abcd);

    // R4 rewrite while busy is dropped
    expect_lf(4'h5, 24'h111111, 24'h00abcd);
    wr_reg(3'd1, 24'h111111);
    wr_reg(3'd1, 24'h222222);
    rd_reg(3'd4, r); chk("R4 error set", r[3], 1);
    rd_reg(3'd1, r); chk("R4 shadow kept", r, 24'h111111);
    wait_idle("R4 idle");
    chk("R4 slow kept", lf_cmpa, 24'h111111);

    // R5 sticky error and clear
    wr_reg(3'd0, 24'h0); // goes through? ctrl idle -> accepted
    expect_lf(4'h0, 24'h111111, 24'h00abcd);
    wait_idle("R5 idle");
    rd_reg(3'd4, r); chk("R5 error sticky", r[3], 1);
    wr_reg(3'd4, 24'h0);
    rd_reg(3'd4, r); chk("R5 no clear without bit3", r[3], 1);
    wr_reg(3'd4, 24'h8);
    rd_reg(3'd4, r); chk("R5 error cleared", r[3], 0);

    // R6/R7 hold mode
    wr_reg(3'd3, 24'h1);
    rd_reg(3'd3, r); chk("R6 hold reads 1", r, 1);
    wr_reg(3'd0, 24'h9);
    wr_reg(3'd2, 24'h0f0f0f);
    wr_reg(3'd2, 24'h0e0e0e);
    rd_reg(3'd4, r); chk("R6 dirty no busy no err", r[7:0], 8'h50);
    rd_reg(3'd2, r); chk("R6 shadow rewritten", r, 24'h0e0e0e);
    repeat (40) @(negedge lf_clk);
    chk("R7 slow held", {lf_ctrl, lf_cmpb}, {4'h0, 24'h00abcd});

    // R8/R9 release
    expect_lf(4'h9, 24'h111111, 24'h0e0e0e);
    wr_reg(3'd3, 24'h0);
    rd_reg(3'd4, r); chk("R8 busy equals dirty", r[7:0], 8'h05);
    wait_idle("R8 idle");
    chk("R9 slow after release", {lf_ctrl, lf_cmpa, lf_cmpb}, {4'h9, 24'h111111, 24'h0e0e0e});

    // R8 release with a single dirty register
    wr_reg(3'd3, 24'h1);
    wr_reg(3'd1, 24'h333333);
    rd_reg(3'd4, r); chk("R6 single dirty", r[7:0], 8'h20);
    expect_lf(4'h9, 24'h333333, 24'h0e0e0e);
    wr_reg(3'd3, 24'h0);
    rd_reg(3'd4, r); chk("R8 single busy", r[7:0], 8'h02);
    wait_idle("R8 idle 2");

    repeat (20) @(negedge lf_clk);
    chk("R10 all updates delivered", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule